// File: doc/BRIEF.md
# Four-Lane Deskew Aligner

The block takes four received lanes that share one clock and have already been word-aligned and decoded. It removes the skew between them so that each output column carries symbols that were sent together. Each symbol is an 8-bit byte plus a control (K) flag. Every lane writes into its own small circular buffer. A detector on each lane watches for the alignment character, a control symbol with byte value 0x7C. For each lane, the buffer slot that received the first such character is recorded.

Reading starts only after every lane has recorded an alignment character within the skew window. All four read pointers are then loaded with their recorded slots and advance together. From that point on, the outputs present lined-up columns and `align_status` is high. Once aligned, the block keeps checking columns that contain alignment characters. It drops alignment after repeated partial columns, or at once when any lane reports loss of sync. It then hunts for alignment again.

Top module: `deskew_aligner`

## Requirements
- R1: After reset, `align_status` is 0 and every output lane (`out_k`, `out_data`) is 0.
- R2: Only a symbol with K=1 and byte 0x7C counts as the alignment character. Byte 0x7C with K=0, and other control bytes (0xBC, 0x1C, 0xFC, 0x3C), are never detected.
- R3: Let t_last be the clock cycle in which the last lane presents its first alignment character, with the earliest lane no more than DEPTH-1 cycles before it. Then, at the second rising edge after t_last, `align_status` rises and the outputs hold a full column of alignment characters. On each following edge, every lane outputs its own input stream, shifted so that the columns stay lined up. Lane i is at byte position [8i+7:8i] of the data buses and at bit i of the K buses.
- R4: Hunting runs only while all four `lane_sync` bits are 1. Alignment characters seen while any bit is 0 are ignored. If any bit goes to 0 while aligned, `align_status` is 0 after the next edge, and the block must see a new alignment column to realign.
- R5: If a lane's first alignment character is still unmatched by all others DEPTH-1 cycles after the earliest capture, all captures are discarded and hunting restarts. A skew of DEPTH or more cycles never aligns.
- R6: While aligned, a partial column is one in which some lanes, but not all, carry the alignment character. After the fourth such column in a row, that column is still output, and on the following edge `align_status` and the outputs go to 0. Columns without any alignment character do not break the run.
- R7: While `align_status` is 0, all output lanes are 0.
- R8: A column in which all lanes carry the alignment character clears the partial-column run, so three partial columns, one full column and three more partial columns keep alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all lanes |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_sync | input | 4 | Per-lane word-sync good flags |
| rx_k | input | 4 | Per-lane control flag of the incoming symbol |
| rx_data | input | 32 | Per-lane incoming bytes, lane i at [8i+7:8i] |
| out_k | output | 4 | Per-lane control flag of the aligned column |
| out_data | output | 32 | Per-lane aligned bytes, lane i at [8i+7:8i] |
| align_status | output | 1 | High while the output columns are aligned |

## Verification
The assertions assume the four lanes differ only by a fixed delay. They also assume that stray alignment characters on a single lane appear only where a scenario places them on purpose. The stimulus derives every lane from one column stream, delays each lane by its own fixed skew and fills the columns with seeded random bytes and non-alignment control codes. Alignment characters appear only at marked columns. Skews, drops of sync and partial columns are placed so that each expected rise or fall of `align_status` can be computed from the cycle in which the last lane sees its character.

// File: rtl/deskew_pkg.sv
// Shared definitions for the four-lane deskew aligner.
// Assumes decoded symbols: one byte plus a control flag per lane.
package deskew_pkg;

    localparam logic [7:0] ALIGN_BYTE = 8'h7C;

    typedef enum logic {
        ST_HUNT    = 1'b0,
        ST_ALIGNED = 1'b1
    } dsk_state_e;

    // True when a symbol is the alignment control character.
    function automatic logic is_align(input logic k, input logic [7:0] d);
        return k && (d == ALIGN_BYTE);
    endfunction

endpackage

// File: rtl/deskew_lane_fifo.sv
// Per-lane deskew buffer: a circular store that writes every cycle,
// flags the first alignment character seen while hunting and records
// the slot it went into. On load the read pointer takes that slot;
// afterwards it advances once per read cycle.
// Assumes DEPTH is a power of two and one clock for write and read.
module deskew_lane_fifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_k,
    input  logic [7:0] in_data,
    input  logic       hunt_en,
    input  logic       clear,
    input  logic       load,
    input  logic       rd_en,
    output logic       hit,
    output logic       adet,
    output logic       rd_k,
    output logic [7:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [8:0]    mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;
    logic [AW-1:0] cap_q;

    assign hit = deskew_pkg::is_align(in_k, in_data);

    // Store every incoming symbol.
    always_ff @(posedge clk) begin
        mem[wp_q] <= {in_k, in_data};
    end

    // Free-running write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= '0;
        else        wp_q <= wp_q + 1'b1;
    end

    // Remember the first alignment character of this hunt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adet  <= 1'b0;
            cap_q <= '0;
        end else if (clear) begin
            adet  <= 1'b0;
        end else if (hunt_en && hit && !adet) begin
            adet  <= 1'b1;
            cap_q <= wp_q;
        end
    end

    // Read pointer: start at the captured slot, then step with reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rp_q <= '0;
        else if (load)  rp_q <= adet ? cap_q : wp_q;
        else if (rd_en) rp_q <= rp_q + 1'b1;
    end

    assign rd_k    = mem[rp_q][8];
    assign rd_data = mem[rp_q][7:0];

    // R2: a detection flag is held until the controller discards it.
    a_r2_adet_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (adet && !clear) |=> adet);

    // R2: a flag only rises on a cycle that presented the character.
    a_r2_adet_source : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adet) |-> $past(in_k && in_data == deskew_pkg::ALIGN_BYTE));

endmodule

// File: rtl/deskew_ctrl.sv
// Common deskew controller: hunts until every lane has a captured
// alignment character inside the skew window, then enables reading of
// all lanes together and monitors output columns for partial alignment.
// Assumes lane inputs are already word-synchronized on one clock.
module deskew_ctrl #(
    parameter int NUM_LANES = 4,
    parameter int DEPTH     = 8,
    parameter int BAD_LIMIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_sync,
    input  logic [NUM_LANES-1:0] hit,
    input  logic [NUM_LANES-1:0] adet,
    input  logic [NUM_LANES-1:0] rd_hit,
    output logic                 hunt_en,
    output logic                 clear,
    output logic                 load,
    output logic                 rd_en,
    output logic                 align_status
);
    import deskew_pkg::*;

    localparam int SW = $clog2(DEPTH);
    localparam int BW = $clog2(BAD_LIMIT + 1);
    localparam logic [SW-1:0] SKEW_LAST = SW'(DEPTH - 2);
    localparam logic [BW-1:0] BAD_LAST  = BW'(BAD_LIMIT - 1);

    dsk_state_e    state_q, state_d;
    logic [SW-1:0] skew_q, skew_d;
    logic [BW-1:0] bad_q, bad_d;
    logic          ok, all_now, any_adet, col_full, col_part;

    assign ok       = &lane_sync;
    assign hunt_en  = (state_q == ST_HUNT) && ok;
    assign rd_en    = (state_q == ST_ALIGNED) && ok;
    assign all_now  = &(adet | hit);
    assign any_adet = |adet;
    assign col_full = &rd_hit;
    assign col_part = (|rd_hit) && !col_full;

    // Next-state, skew window and partial-column bookkeeping.
    always_comb begin
        state_d = state_q;
        skew_d  = skew_q;
        bad_d   = bad_q;
        clear   = 1'b0;
        load    = 1'b0;
        if (!ok) begin
            state_d = ST_HUNT;
            clear   = 1'b1;
            skew_d  = '0;
            bad_d   = '0;
        end else if (state_q == ST_HUNT) begin
            bad_d = '0;
            if (all_now) begin
                load    = 1'b1;
                clear   = 1'b1;
                state_d = ST_ALIGNED;
                skew_d  = '0;
            end else if (any_adet && skew_q == SKEW_LAST) begin
                clear  = 1'b1;
                skew_d = '0;
            end else if (any_adet) begin
                skew_d = skew_q + 1'b1;
            end else begin
                skew_d = '0;
            end
        end else begin
            if (col_full) begin
                bad_d = '0;
            end else if (col_part) begin
                if (bad_q == BAD_LAST) begin
                    state_d = ST_HUNT;
                    clear   = 1'b1;
                    bad_d   = '0;
                end else begin
                    bad_d = bad_q + 1'b1;
                end
            end
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            skew_q  <= '0;
            bad_q   <= '0;
        end else begin
            state_q <= state_d;
            skew_q  <= skew_d;
            bad_q   <= bad_d;
        end
    end

    // Status follows the read enable, in step with the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) align_status <= 1'b0;
        else        align_status <= rd_en;
    end

    // R4: losing sync on any lane removes alignment on the next edge.
    a_r4_sync_loss : assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_sync) |=> !align_status);

    // R5: the skew window counter never passes its last value.
    a_r5_skew_window : assert property (@(posedge clk) disable iff (!rst_n)
        skew_q <= SKEW_LAST);

    // R6: the partial-column run stays below its limit.
    a_r6_bad_bound : assert property (@(posedge clk) disable iff (!rst_n)
        bad_q <= BAD_LAST);

endmodule

// File: rtl/deskew_aligner.sv
// Four-lane deskew aligner top: one deskew buffer per lane, a common
// controller, and registered aligned outputs that read zero while the
// lanes are not aligned. Assumes one clock for all lanes.
module deskew_aligner #(
    parameter int NUM_LANES = 4,
    parameter int DEPTH     = 8,
    parameter int BAD_LIMIT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LANES-1:0]   lane_sync,
    input  logic [NUM_LANES-1:0]   rx_k,
    input  logic [NUM_LANES*8-1:0] rx_data,
    output logic [NUM_LANES-1:0]   out_k,
    output logic [NUM_LANES*8-1:0] out_data,
    output logic                   align_status
);
    localparam int DW = NUM_LANES * 8;

    logic [NUM_LANES-1:0] hit, adet, rd_k, rd_hit;
    logic [DW-1:0]        rd_data;
    logic                 hunt_en, clear, load, rd_en;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        deskew_lane_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_k    (rx_k[g]),
            .in_data (rx_data[8*g +: 8]),
            .hunt_en (hunt_en),
            .clear   (clear),
            .load    (load),
            .rd_en   (rd_en),
            .hit     (hit[g]),
            .adet    (adet[g]),
            .rd_k    (rd_k[g]),
            .rd_data (rd_data[8*g +: 8])
        );
        assign rd_hit[g] = deskew_pkg::is_align(rd_k[g], rd_data[8*g +: 8]);
    end

    deskew_ctrl #(
        .NUM_LANES (NUM_LANES),
        .DEPTH     (DEPTH),
        .BAD_LIMIT (BAD_LIMIT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_sync    (lane_sync),
        .hit          (hit),
        .adet         (adet),
        .rd_hit       (rd_hit),
        .hunt_en      (hunt_en),
        .clear        (clear),
        .load         (load),
        .rd_en        (rd_en),
        .align_status (align_status)
    );

    // Output register: aligned column while reading, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_en) begin
            out_k    <= '0;
            out_data <= '0;
        end else begin
            out_k    <= rd_k;
            out_data <= rd_data;
        end
    end

    // R3: alignment starts on a full column of alignment characters.
    a_r3_first_column : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(align_status) |-> (&out_k && out_data == {NUM_LANES{deskew_pkg::ALIGN_BYTE}}));

    // R7: outputs are quiet whenever alignment is absent.
    a_r7_quiet_outputs : assert property (@(posedge clk) disable iff (!rst_n)
        !align_status |-> (out_k == '0 && out_data == '0));

endmodule

// File: tb/deskew_aligner_tb.sv
module deskew_aligner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lane_sync = '1;
    logic [NL-1:0] rx_k = '0;
    logic [NL*8-1:0] rx_data = '0;
    logic [NL-1:0] out_k;
    logic [NL*8-1:0] out_data;
    logic          align_status;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] rnd [256];
    bit         amark [256][NL];
    int         skew [NL];
    int         sl_from, sl_to, sl_lane;
    logic [7:0] kset [4] = '{8'hBC, 8'h1C, 8'hFC, 8'h3C};

    always #(CLK_PERIOD/2) clk = ~clk;

    deskew_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .lane_sync(lane_sync), .rx_k(rx_k),
        .rx_data(rx_data), .out_k(out_k), .out_data(out_data),
        .align_status(align_status)
    );

    // Symbol of column n on lane i.
    function automatic logic [8:0] sym(input int n, input int i);
        logic [7:0] h;
        if (n < 0) return {1'b1, 8'hBC};
        if (n < 256 && amark[n][i]) return {1'b1, 8'h7C};
        h = rnd[(n * 7 + i * 61) & 255];
        if (h[7:6] == 2'b11) return {1'b1, kset[h[1:0]]};
        return {1'b0, h};
    endfunction

    task automatic clear_marks();
        for (int n = 0; n < 256; n++)
            for (int i = 0; i < NL; i++) amark[n][i] = 1'b0;
        sl_from = -1; sl_to = -1; sl_lane = 0;
    endtask

    task automatic mark_col(input int n);
        for (int i = 0; i < NL; i++) amark[n][i] = 1'b1;
    endtask

    task automatic set_skew(input int a, input int b, input int c, input int d);
        skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
    endtask

    // Runs ncyc cycles after reset; windows give aligned ranges.
    task automatic run(input int ncyc, input int w1f, input int w1t, input int nb1,
                       input int w2f, input int w2t, input int nb2, input string tag);
        logic [NL-1:0]   ek;
        logic [NL*8-1:0] ed;
        logic            ea;
        logic [8:0]      s;
        string           t;
        int              n;
        rst_n = 1'b0;
        lane_sync = '1;
        repeat (3) @(negedge clk);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            ea = 1'b0; ek = '0; ed = '0; n = 0;
            if (c >= w1f && c < w1t) begin ea = 1'b1; n = nb1 + c - w1f; end
            else if (c >= w2f && c < w2t) begin ea = 1'b1; n = nb2 + c - w2f; end
            if (ea) begin
                for (int i = 0; i < NL; i++) begin
                    s = sym(n, i);
                    ek[i] = s[8];
                    ed[8*i +: 8] = s[7:0];
                end
            end
            t = (c == 0) ? "R1" : (ea ? tag : {tag, "/R7"});
            n_checks++;
            if (align_status !== ea || out_k !== ek || out_data !== ed) begin
                n_fail++;
                $display("FAIL %s cycle %0d: align=%b k=%h data=%h expected align=%b k=%h data=%h",
                         t, c, align_status, out_k, out_data, ea, ek, ed);
            end
            rst_n = 1'b1;
            for (int i = 0; i < NL; i++) begin
                s = sym(c - skew[i], i);
                rx_k[i] = s[8];
                rx_data[8*i +: 8] = s[7:0];
                lane_sync[i] = !(c >= sl_from && c < sl_to && i == sl_lane);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int mx, na, dummy;
        dummy = $urandom(32'h5EED);
        for (int j = 0; j < 256; j++) rnd[j] = 8'($urandom);
        rnd[0] = 8'h7C; rnd[100] = 8'h7C; rnd[37] = 8'h7C; // R2 distractors (K=0)

        // R3: moderate skew, last lane at cycle 15
        clear_marks(); set_skew(0, 3, 1, 5); mark_col(10);
        run(60, 17, 60, 10, -1, -1, 0, "R3");

        // R2: equal skew, random bytes with 0x7C as data and other K codes
        clear_marks(); set_skew(2, 2, 2, 2); mark_col(12);
        run(50, 16, 50, 12, -1, -1, 0, "R2");

        // R5: largest skew that still aligns (DEPTH-1)
        clear_marks(); set_skew(7, 0, 2, 4); mark_col(10);
        run(60, 19, 60, 10, -1, -1, 0, "R5");

        // R5: skew of DEPTH never aligns
        clear_marks(); set_skew(8, 0, 0, 0); mark_col(10); mark_col(30);
        run(70, -1, -1, 0, -1, -1, 0, "R5");

        // R5: stray character on one lane times out, then real column aligns
        clear_marks(); set_skew(1, 0, 2, 0); amark[3][0] = 1'b1; mark_col(20);
        run(70, 24, 70, 20, -1, -1, 0, "R5");

        // R6: four partial columns in a row drop alignment
        clear_marks(); set_skew(0, 3, 1, 5); mark_col(10);
        amark[15][2] = 1'b1; amark[17][2] = 1'b1; amark[19][2] = 1'b1; amark[21][2] = 1'b1;
        run(60, 17, 29, 10, -1, -1, 0, "R6");

        // R8: a full column between partial runs keeps alignment
        clear_marks(); set_skew(0, 3, 1, 5); mark_col(10);
        amark[15][2] = 1'b1; amark[17][2] = 1'b1; amark[19][2] = 1'b1; mark_col(20);
        amark[22][2] = 1'b1; amark[24][2] = 1'b1; amark[26][2] = 1'b1;
        run(70, 17, 70, 10, -1, -1, 0, "R8");

        // R4: sync loss drops alignment; column during loss ignored; new column realigns
        clear_marks(); set_skew(0, 3, 1, 5); mark_col(10); mark_col(30); mark_col(50);
        sl_from = 30; sl_to = 36; sl_lane = 1;
        run(90, 17, 31, 10, 57, 90, 50, "R4");

        // R3: seeded random skews within the window
        for (int r = 0; r < 4; r++) begin
            clear_marks();
            mx = 0;
            for (int i = 0; i < NL; i++) begin
                skew[i] = int'($urandom % 8);
                if (skew[i] > mx) mx = skew[i];
            end
            na = 8 + int'($urandom % 8);
            mark_col(na);
            run(na + mx + 40, na + mx + 2, na + mx + 40, na, -1, -1, 0, "R3");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule